// File: doc/BRIEF.md
# I2C Byte-Transfer Master with Event Flags

This block is the bus-side engine of a single-master I2C controller. It runs one transfer to a target with a 7-bit address. The transfer can write a number of bytes or read a number of bytes. A transfer starts with a single-cycle `cmdStart` strobe, which captures the address, the direction and the byte count. The block then generates the START condition, the address frame, the data frames and the STOP condition with no further help. Write bytes are taken from `wrData`, and each time one is consumed `wrTake` pulses. Read bytes appear on `rdData` with a single-cycle `rdValid` pulse.

Bus timing comes from a programmable divider, `clkDiv`. Each SCL bit is split into four quarters, and each quarter lasts `clkDiv+1` clock cycles. SCL is low in the first two quarters and high in the last two.

Three events are latched in a flag register: transfer done, address not acknowledged and data not acknowledged. A matching enable mask decides which flags reach the single interrupt line. Software clears a flag by writing a one to its bit.

SDA is always open-drain. SCL can be open-drain or push-pull, selected by `sclPushPull`.

Top module: `i2cEvtMaster`

## Requirements
- R1: After reset the block is idle: `busy`, `flags`, `irq`, `sdaOe`, `sclOe` and `sclOut` are all 0, so both lines are released.
- R2: A transfer opens with SDA falling while SCL is high. The first frame is the 7-bit address, MSB first, followed by the direction bit (0 = write, 1 = read).
- R3: In a write, each data byte is sent MSB first from `wrData`. `wrTake` pulses once per byte consumed. SDA is released on the ninth clock so the target's acknowledge can be sampled there.
- R4: In a read, SDA is released for eight bits and the byte is assembled MSB first. The byte is presented on `rdData` with a one-cycle `rdValid` pulse. The master drives SDA low on the ninth clock of every read byte.
- R5: Apart from the opening START and the closing STOP, SDA changes only while SCL is low. Every transfer shows exactly one START and one STOP (SDA rising while SCL is high).
- R6: If the address is not acknowledged, no data frame is clocked. The block issues STOP and sets flag bit 1 (address NACK) together with bit 0 (done).
- R7: If a written byte is not acknowledged, no further byte is taken or clocked. The block issues STOP and sets flag bit 2 (data NACK) together with bit 0.
- R8: `busy` stays high for exactly 4·(clkDiv+1)·(2+9·F) cycles, counted from the edge that accepts `cmdStart`. F is the number of frames clocked, including the address frame. Flag bit 0 is set on the edge where `busy` falls.
- R9: A flag is set by its event whatever the enable mask holds. `irq` is high when any flag bit has its `irqEn` bit set.
- R10: A 1 in `flagClr` clears only that flag bit, on the next edge. Bits written as 0 are left unchanged.
- R11: With `sclPushPull` = 0, `sclOut` is always 0 and SCL low is signalled by `sclOe`. With `sclPushPull` = 1, `sclOe` is always 1 and `sclOut` carries the SCL level.
- R12: A byte count of 0 gives an address-only transfer. After the address acknowledge the block goes straight to STOP and sets only flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | Start strobe, accepted only when idle |
| cmdAddr | input | 7 | Target address |
| cmdRead | input | 1 | Direction: 1 = read, 0 = write |
| cmdCount | input | CNT_W | Number of data bytes |
| wrData | input | 8 | Next byte to write |
| wrTake | output | 1 | Pulse: `wrData` was consumed |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | Pulse: `rdData` is new |
| busy | output | 1 | Transfer in progress |
| clkDiv | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| sclPushPull | input | 1 | 1 = SCL push-pull, 0 = SCL open-drain |
| sclOut | output | 1 | SCL level, used in push-pull mode |
| sclOe | output | 1 | SCL driver enable |
| sdaOe | output | 1 | SDA pull-low enable |
| sdaIn | input | 1 | SDA line level |
| irqEn | input | 3 | Interrupt enable per flag bit |
| flagClr | input | 3 | Write-one-to-clear per flag bit |
| flags | output | 3 | Bit 0 done, bit 1 address NACK, bit 2 data NACK |
| irq | output | 1 | Interrupt request |

## Verification
All results are due at a cycle that can be predicted from the command:
- `busy` lasts 4·(clkDiv+1)·(2+9·F) cycles from the accepting edge. The flags settle on the edge where `busy` drops.
- `rdValid` and `wrTake` come one cycle after the frame edge that causes them.

The bench drives its inputs on falling edges and samples on falling edges. It counts the falling edges on which `busy` is high and compares that count with the formula. It reads the flags and `irq` only after `busy` has dropped. A bus-level target model reacts to the SCL and SDA line edges themselves. It records START and STOP events, the address and data bytes it sees, and the master's acknowledges, so protocol results are independent of the clock phase.

// File: rtl/i2cEvtPkg.sv
package i2cEvtPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} phaseT;

  localparam int FLAG_W     = 3;
  localparam int FLAG_DONE  = 0;
  localparam int FLAG_ANACK = 1;
  localparam int FLAG_DNACK = 2;

  typedef struct packed {
    logic run;
    logic loadAddr;
    logic loadWr;
    logic shiftIn;
    logic shiftOut;
    logic sdaSet;
    logic sdaVal;
    logic rdDone;
    logic setDone;
    logic setAddrNack;
    logic setDataNack;
  } strobeT;
endpackage

// File: rtl/i2cEvtCtrl.sv
module i2cEvtCtrl
  import i2cEvtPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic             cmdRead,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             tick,
  input  logic             shiftMsb,
  input  logic             sdaIn,
  output strobeT           stb,
  output logic             sclLow,
  output logic             busy,
  output logic             inBit
);
  localparam logic [3:0] ACK_IDX = 4'd8;

  phaseT            state;
  logic [1:0]       quarter;
  logic [3:0]       bitIdx;
  logic             isAddr;
  logic             readMode;
  logic [CNT_W-1:0] byteLeft;
  logic             drivesBit;
  logic             lastFrame;

  assign drivesBit = isAddr || !readMode;
  assign lastFrame = isAddr ? (byteLeft == '0) : (byteLeft == CNT_W'(1));
  assign sclLow    = ((state == ST_BIT) || (state == ST_STOP)) && !quarter[1];
  assign busy      = (state != ST_IDLE);
  assign inBit     = (state == ST_BIT);

  always_comb begin
    stb     = '0;
    stb.run = (state != ST_IDLE);
    if ((state == ST_IDLE) && cmdStart) stb.loadAddr = 1'b1;
    if (tick) begin
      case (state)
        ST_START: if (quarter == 2'd1) begin
          stb.sdaSet = 1'b1;
          stb.sdaVal = 1'b1;
        end
        ST_BIT: begin
          if (quarter == 2'd0) begin
            stb.sdaSet = 1'b1;
            if (bitIdx < ACK_IDX) stb.sdaVal = drivesBit && !shiftMsb;
            else                  stb.sdaVal = !drivesBit;
          end
          if (quarter == 2'd3) begin
            if (bitIdx < ACK_IDX) begin
              stb.shiftOut = drivesBit;
              stb.shiftIn  = !drivesBit;
            end else if (drivesBit) begin
              if (sdaIn) begin
                stb.setAddrNack = isAddr;
                stb.setDataNack = !isAddr;
              end else if (!readMode && !lastFrame) begin
                stb.loadWr = 1'b1;
              end
            end else begin
              stb.rdDone = 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (quarter == 2'd0) begin
            stb.sdaSet = 1'b1;
            stb.sdaVal = 1'b1;
          end
          if (quarter == 2'd2) begin
            stb.sdaSet = 1'b1;
            stb.sdaVal = 1'b0;
          end
          if (quarter == 2'd3) stb.setDone = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      quarter  <= '0;
      bitIdx   <= '0;
      isAddr   <= 1'b0;
      readMode <= 1'b0;
      byteLeft <= '0;
    end else if (state == ST_IDLE) begin
      if (cmdStart) begin
        state    <= ST_START;
        quarter  <= '0;
        bitIdx   <= '0;
        isAddr   <= 1'b1;
        readMode <= cmdRead;
        byteLeft <= cmdCount;
      end
    end else if (tick) begin
      quarter <= quarter + 2'd1;
      if (quarter == 2'd3) begin
        case (state)
          ST_START: begin
            state  <= ST_BIT;
            bitIdx <= '0;
          end
          ST_BIT: begin
            if (bitIdx != ACK_IDX) begin
              bitIdx <= bitIdx + 4'd1;
            end else begin
              bitIdx <= '0;
              isAddr <= 1'b0;
              if (!isAddr) byteLeft <= byteLeft - CNT_W'(1);
              if ((drivesBit && sdaIn) || lastFrame) state <= ST_STOP;
            end
          end
          ST_STOP: state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  AST_SAMPLE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftIn |-> (readMode && !isAddr)); // R4
endmodule

// File: rtl/i2cEvtDatapath.sv
module i2cEvtDatapath
  import i2cEvtPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [6:0]        cmdAddr,
  input  logic              cmdRead,
  input  logic [7:0]        wrData,
  input  logic              sdaIn,
  input  logic [FLAG_W-1:0] irqEn,
  input  logic [FLAG_W-1:0] flagClr,
  output logic              tick,
  output logic              shiftMsb,
  output logic              sdaLow,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              wrTake,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic [DIV_W-1:0]  divCnt;
  logic [7:0]        shiftReg;
  logic [FLAG_W-1:0] setMask;

  assign tick     = stb.run && (divCnt == clkDiv);
  assign shiftMsb = shiftReg[7];

  always_comb begin
    setMask             = '0;
    setMask[FLAG_DONE]  = stb.setDone;
    setMask[FLAG_ANACK] = stb.setAddrNack;
    setMask[FLAG_DNACK] = stb.setDataNack;
  end

  assign irq = |(flags & irqEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      shiftReg <= '0;
      sdaLow   <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
      wrTake   <= 1'b0;
      flags    <= '0;
    end else begin
      divCnt <= (!stb.run || tick) ? '0 : divCnt + DIV_W'(1);
      if (stb.loadAddr)      shiftReg <= {cmdAddr, cmdRead};
      else if (stb.loadWr)   shiftReg <= wrData;
      else if (stb.shiftOut) shiftReg <= {shiftReg[6:0], 1'b0};
      else if (stb.shiftIn)  shiftReg <= {shiftReg[6:0], sdaIn};
      if (stb.sdaSet) sdaLow <= stb.sdaVal;
      if (stb.rdDone) rdData <= shiftReg;
      rdValid <= stb.rdDone;
      wrTake  <= stb.loadWr;
      flags   <= (flags & ~flagClr) | setMask;
    end
  end

  AST_NACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setAddrNack && stb.setDataNack)); // R6

  for (genvar i = 0; i < FLAG_W; i++) begin : gFlagChk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !flagClr[i]) |=> flags[i]); // R9
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN)
      (flagClr[i] && !setMask[i]) |=> !flags[i]); // R10
  end
endmodule

// File: rtl/i2cEvtMaster.sv
module i2cEvtMaster
  import i2cEvtPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [6:0]       cmdAddr,
  input  logic             cmdRead,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic [7:0]       wrData,
  output logic             wrTake,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             busy,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             sclPushPull,
  output logic             sclOut,
  output logic             sclOe,
  output logic             sdaOe,
  input  logic             sdaIn,
  input  logic [2:0]       irqEn,
  input  logic [2:0]       flagClr,
  output logic [2:0]       flags,
  output logic             irq
);
  strobeT stb;
  logic   tick;
  logic   shiftMsb;
  logic   sclLow;
  logic   inBit;
  logic   sdaLow;

  i2cEvtCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cmdCount(cmdCount), .tick(tick), .shiftMsb(shiftMsb), .sdaIn(sdaIn),
    .stb(stb), .sclLow(sclLow), .busy(busy), .inBit(inBit)
  );

  i2cEvtDatapath #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .clkDiv(clkDiv), .cmdAddr(cmdAddr),
    .cmdRead(cmdRead), .wrData(wrData), .sdaIn(sdaIn), .irqEn(irqEn),
    .flagClr(flagClr), .tick(tick), .shiftMsb(shiftMsb), .sdaLow(sdaLow),
    .rdData(rdData), .rdValid(rdValid), .wrTake(wrTake), .flags(flags), .irq(irq)
  );

  assign sdaOe  = sdaLow;
  assign sclOe  = sclPushPull ? 1'b1 : sclLow;
  assign sclOut = sclPushPull ? !sclLow : 1'b0;

  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (inBit && $past(inBit) && !sclLow && !$past(sclLow)) |-> $stable(sdaOe)); // R5
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> flags[FLAG_DONE]); // R8
endmodule

// File: tb/i2cEvtMaster_tb.sv
module i2cEvtMaster_tb_top;
  localparam logic [6:0] TGT_ADDR = 7'h52;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdStart = 1'b0;
  logic [6:0] cmdAddr = '0;
  logic       cmdRead = 1'b0;
  logic [3:0] cmdCount = '0;
  logic [7:0] wrData = '0;
  logic       wrTake;
  logic [7:0] rdData;
  logic       rdValid;
  logic       busy;
  logic [7:0] clkDiv = 8'd1;
  logic       sclPushPull = 1'b0;
  logic       sclOut, sclOe, sdaOe;
  logic [2:0] irqEn = '0;
  logic [2:0] flagClr = '0;
  logic [2:0] flags;
  logic       irq;
  logic       tgtPull = 1'b0;
  logic       sclBus, sdaBus;

  int nChecks = 0;
  int nFails  = 0;

  // target model state
  int         startCnt = 0, stopCnt = 0, bitCnt = 0, frameIdx = 0;
  int         dataFrames = 0, masterAcks = 0, nackAt = -1, readLen = 0;
  logic [7:0] rxByte = '0, addrByte = '0;
  logic       rwSeen = 1'b0, addrOk = 1'b0;
  logic [7:0] rxLog [8];
  logic [7:0] rdSrc [8];
  logic [7:0] wrSrc [8];
  logic [7:0] rdCap [8];
  int         rdCnt = 0, wrTakes = 0, sclBad = 0;

  always #4 clk = ~clk;

  assign sclBus = sclOe ? sclOut : 1'b1;
  assign sdaBus = (sdaOe || tgtPull) ? 1'b0 : 1'b1;

  i2cEvtMaster dut_i (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdAddr(cmdAddr),
    .cmdRead(cmdRead), .cmdCount(cmdCount), .wrData(wrData), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .clkDiv(clkDiv),
    .sclPushPull(sclPushPull), .sclOut(sclOut), .sclOe(sclOe), .sdaOe(sdaOe),
    .sdaIn(sdaBus), .irqEn(irqEn), .flagClr(flagClr), .flags(flags), .irq(irq)
  );

  always @(negedge sdaBus) if (sclBus === 1'b1) begin
    startCnt++; bitCnt = 0; frameIdx = 0; tgtPull = 1'b0;
  end

  always @(posedge sdaBus) if (sclBus === 1'b1) stopCnt++;

  always @(posedge sclBus) begin
    if (bitCnt < 8) begin
      rxByte = {rxByte[6:0], sdaBus};
      bitCnt++;
    end else begin
      if (frameIdx == 0) begin
        addrByte = rxByte; rwSeen = rxByte[0]; addrOk = !sdaBus;
      end else begin
        dataFrames++;
        if (!rwSeen) rxLog[(frameIdx-1) % 8] = rxByte;
        else if (!sdaBus) masterAcks++;
      end
      bitCnt = 0;
      frameIdx++;
    end
  end

  always @(negedge sclBus) begin
    if (bitCnt == 8) begin
      if (frameIdx == 0)  tgtPull = (rxByte[7:1] == TGT_ADDR);
      else if (!rwSeen)   tgtPull = (frameIdx != nackAt);
      else                tgtPull = 1'b0;
    end else if (frameIdx > 0 && rwSeen && addrOk && frameIdx <= readLen) begin
      tgtPull = !rdSrc[(frameIdx-1) % 8][7-bitCnt];
    end else begin
      tgtPull = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearFlags(input logic [2:0] m);
    @(negedge clk); flagClr = m;
    @(negedge clk); flagClr = '0;
  endtask

  task automatic runXfer(input logic [6:0] a, input logic rd, input int n,
                         input int div, output int cyc);
    startCnt = 0; stopCnt = 0; dataFrames = 0; masterAcks = 0;
    rdCnt = 0; wrTakes = 0; sclBad = 0;
    @(negedge clk);
    cmdAddr = a; cmdRead = rd; cmdCount = n[3:0]; clkDiv = div[7:0];
    wrData = wrSrc[0]; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    cyc = 0;
    while (busy && cyc < 20000) begin
      if (!sclPushPull && sclOut !== 1'b0) sclBad++;
      if (sclPushPull && sclOe !== 1'b1) sclBad++;
      if (rdValid) begin rdCap[rdCnt % 8] = rdData; rdCnt++; end
      if (wrTake) begin wrTakes++; wrData = wrSrc[wrTakes % 8]; end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic testReset;
    chk("R1 busy", busy, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 line drivers", {sdaOe, sclOe, sclOut}, 3'b000);
  endtask

  task automatic testWrite;
    int cyc;
    wrSrc[0] = 8'hA5; wrSrc[1] = 8'h3C; nackAt = -1; irqEn = 3'b000;
    runXfer(TGT_ADDR, 1'b0, 2, 1, cyc);
    chk("R2 address frame", addrByte, {TGT_ADDR, 1'b0});
    chk("R3 byte0", rxLog[0], 8'hA5);
    chk("R3 byte1", rxLog[1], 8'h3C);
    chk("R3 wrTake count", wrTakes, 2);
    chk("R5 start count", startCnt, 1);
    chk("R5 stop count", stopCnt, 1);
    chk("R8 busy cycles", cyc, 4*2*(2+9*3));
    chk("R8 done flag", flags, 3'b001);
    chk("R11 open-drain scl", sclBad, 0);
    chk("R9 masked irq", irq, 0);
    @(negedge clk); irqEn = 3'b001;
    @(negedge clk);
    chk("R9 enabled irq", irq, 1);
    clearFlags(3'b001);
    chk("R10 clear done", flags, 3'b000);
    irqEn = 3'b000;
  endtask

  task automatic testRead;
    int cyc;
    rdSrc[0] = 8'hC3; rdSrc[1] = 8'h5A; rdSrc[2] = 8'h0F; readLen = 3;
    runXfer(TGT_ADDR, 1'b1, 3, 2, cyc);
    chk("R2 read address frame", addrByte, {TGT_ADDR, 1'b1});
    chk("R4 read count", rdCnt, 3);
    chk("R4 rd0", rdCap[0], 8'hC3);
    chk("R4 rd1", rdCap[1], 8'h5A);
    chk("R4 rd2", rdCap[2], 8'h0F);
    chk("R4 master acks", masterAcks, 3);
    chk("R8 read cycles", cyc, 4*3*(2+9*4));
    chk("R5 read stop", stopCnt, 1);
    clearFlags(3'b111);
    readLen = 0;
  endtask

  task automatic testAddrNack;
    int cyc;
    wrSrc[0] = 8'h11; wrSrc[1] = 8'h22;
    runXfer(TGT_ADDR ^ 7'h01, 1'b0, 2, 1, cyc);
    chk("R6 flags", flags, 3'b011);
    chk("R6 no data frames", dataFrames, 0);
    chk("R6 no wrTake", wrTakes, 0);
    chk("R6 stop issued", stopCnt, 1);
    chk("R8 nack cycles", cyc, 4*2*(2+9*1));
    clearFlags(3'b010);
    chk("R10 selective clear", flags, 3'b001);
    clearFlags(3'b111);
  endtask

  task automatic testDataNack;
    int cyc;
    wrSrc[0] = 8'h11; wrSrc[1] = 8'h22; wrSrc[2] = 8'h33; nackAt = 2;
    runXfer(TGT_ADDR, 1'b0, 3, 1, cyc);
    chk("R7 flags", flags, 3'b101);
    chk("R7 frames clocked", dataFrames, 2);
    chk("R7 wrTake count", wrTakes, 2);
    chk("R7 second byte", rxLog[1], 8'h22);
    chk("R8 data nack cycles", cyc, 4*2*(2+9*3));
    @(negedge clk); irqEn = 3'b100;
    @(negedge clk);
    chk("R9 data nack irq", irq, 1);
    irqEn = 3'b000;
    clearFlags(3'b111);
    nackAt = -1;
  endtask

  task automatic testPushPull;
    int cyc;
    @(negedge clk); sclPushPull = 1'b1;
    @(negedge clk);
    chk("R11 idle push-pull", {sclOe, sclOut}, 2'b11);
    wrSrc[0] = 8'h96;
    runXfer(TGT_ADDR, 1'b0, 1, 0, cyc);
    chk("R11 oe held", sclBad, 0);
    chk("R11 byte", rxLog[0], 8'h96);
    chk("R8 pp cycles", cyc, 4*1*(2+9*2));
    chk("R5 pp start/stop", {startCnt[3:0], stopCnt[3:0]}, 8'h11);
    clearFlags(3'b111);
    @(negedge clk); sclPushPull = 1'b0;
  endtask

  task automatic testZeroCount;
    int cyc;
    runXfer(TGT_ADDR, 1'b0, 0, 1, cyc);
    chk("R12 flags", flags, 3'b001);
    chk("R12 no data", dataFrames, 0);
    chk("R12 cycles", cyc, 4*2*(2+9*1));
    clearFlags(3'b111);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite();
    testRead();
    testAddrNack();
    testDataNack();
    testPushPull();
    testZeroCount();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule